// File: doc/BRIEF.md
# Persist Buffer Request Selector

This block sits inside a fabric switch that holds a nonvolatile persist buffer. Every host request that enters the switch passes through it and leaves on exactly one of two streams: toward the persist buffer controller, or along the ordinary forwarding path toward memory. The choice does not come from address decoding. It depends on whether the buffer currently holds the address, or whether an earlier request to the address is still outstanding.

Two associative tables hold that state. The first is a shadow copy of the buffer's per-address occupancy, kept current by insert and release events from the buffer controller. The second tracks every request this block has dispatched and not yet seen answered. A match in either table steers the request to the buffer controller. A read therefore always reaches the newest copy, and a write to a busy address cannot slip past an older one on the other path. The input is a single ordered stream, so a request that cannot leave holds back all later requests and nothing is reordered.

Top module: `pbsel_top`

## Requirements
- R1: After reset both tables are empty. Every request then takes the normal path, and neither output is valid while `in_valid` is low.
- R2: An event with `ev_insert`=1 makes its address a hit in the same cycle and in every later cycle. An event with `ev_insert`=0 removes the address from the following cycle on, so a lookup in the same cycle as the removal is still a hit. Inserting an address that is already present does not use a second shadow entry.
- R3: Each accepted request takes the lowest-numbered free request-table slot, and that index appears on `bc_slot` or `np_slot`. A response on `rsp_slot` frees the slot from the next cycle on.
- R4: A read or write whose address matches a shadow entry or a live request-table entry goes out on the buffer-controller stream. Any other request goes out on the normal stream. At most one of `bc_valid` and `np_valid` is high.
- R5: A write to an address that has an outstanding request is never presented on the normal stream.
- R6: While all request-table slots are in use, `in_ready` is low and neither output is valid.
- R7: A request is accepted only when the stream it was steered to is ready. The other stream's ready has no effect, and a refused request allocates no slot.
- R8: The write flag, address and data appear unchanged on the selected stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming request valid |
| in_ready | output | 1 | Incoming request accepted this cycle |
| in_write | input | 1 | 1 = write, 0 = read |
| in_addr | input | ADDR_W | Request line address |
| in_data | input | DATA_W | Write data |
| bc_valid | output | 1 | Request valid toward buffer controller |
| bc_ready | input | 1 | Buffer controller can take a request |
| bc_write | output | 1 | Write flag toward buffer controller |
| bc_addr | output | ADDR_W | Address toward buffer controller |
| bc_data | output | DATA_W | Data toward buffer controller |
| bc_slot | output | SLOT_W | Request-table slot of this request |
| np_valid | output | 1 | Request valid on normal path |
| np_ready | input | 1 | Normal path can take a request |
| np_write | output | 1 | Write flag on normal path |
| np_addr | output | ADDR_W | Address on normal path |
| np_data | output | DATA_W | Data on normal path |
| np_slot | output | SLOT_W | Request-table slot of this request |
| ev_valid | input | 1 | Buffer status event valid |
| ev_insert | input | 1 | 1 = address now buffered, 0 = entry released |
| ev_addr | input | ADDR_W | Address of the status event |
| rsp_valid | input | 1 | Response seen for an outstanding request |
| rsp_slot | input | SLOT_W | Slot the response frees |

## Verification
The bench builds the block with four entries, a 4-bit address and 8-bit data. With these values all sixteen addresses can be swept for both reads and writes under several shadow-table contents. Four outstanding requests fill the request table within a few cycles, so the full-table stall, the lowest-free slot choice and refill after a release can all be reached quickly. The small shadow table also makes a wasted duplicate entry visible, because it would crowd out a fourth distinct address.

// File: rtl/pbsel_pkg.sv
package pbsel_pkg;
   typedef enum logic {PATH_NORM = 1'b0, PATH_BUF = 1'b1} path_e;

   function automatic int slot_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pbsel_lowfree.sv
module pbsel_lowfree #(
   parameter int N  = 32,
   parameter int IW = 5
) (
   input  logic [N-1:0]  busy,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            idx = IW'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pbsel_mirror.sv
module pbsel_mirror #(
   parameter int ENTRIES      = 32,
   parameter int ADDR_W       = 40,
   parameter int IW           = 5,
   parameter bit EARLY_INSERT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic              ev_insert,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit
);
   logic [ENTRIES-1:0] vld, ev_match, lk_match;
   logic [IW-1:0]      free_idx;
   logic               free_any, do_ins, do_clr, early;

   pbsel_lowfree #(.N(ENTRIES), .IW(IW)) u_free (
      .busy(vld), .idx(free_idx), .any(free_any));

   assign do_ins = ev_valid && ev_insert && !(|ev_match) && free_any;
   assign do_clr = ev_valid && !ev_insert;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic              vld_q;
      logic [ADDR_W-1:0] tag_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            tag_q <= '0;
         end else if (do_ins && free_idx == IW'(g)) begin
            vld_q <= 1'b1;
            tag_q <= ev_addr;
         end else if (do_clr && ev_match[g]) begin
            vld_q <= 1'b0;
         end
      end
      assign vld[g]      = vld_q;
      assign ev_match[g] = vld_q && (tag_q == ev_addr);
      assign lk_match[g] = vld_q && (tag_q == lk_addr);
   end

   if (EARLY_INSERT) begin : g_early
      assign early = ev_valid && ev_insert && (ev_addr == lk_addr);
   end else begin : g_late
      assign early = 1'b0;
   end

   assign lk_hit = (|lk_match) || early;
endmodule

// File: rtl/pbsel_reqtab.sv
module pbsel_reqtab #(
   parameter int ENTRIES = 32,
   parameter int ADDR_W  = 40,
   parameter int IW      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [ADDR_W-1:0] alloc_addr,
   output logic [IW-1:0]     alloc_idx,
   output logic              full,
   input  logic              rel_en,
   input  logic [IW-1:0]     rel_slot,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit
);
   logic [ENTRIES-1:0] vld, lk_match;
   logic               free_any;

   pbsel_lowfree #(.N(ENTRIES), .IW(IW)) u_free (
      .busy(vld), .idx(alloc_idx), .any(free_any));

   assign full = !free_any;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic              vld_q;
      logic [ADDR_W-1:0] addr_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
         end else if (alloc_en && alloc_idx == IW'(g)) begin
            vld_q  <= 1'b1;
            addr_q <= alloc_addr;
         end else if (rel_en && rel_slot == IW'(g)) begin
            vld_q  <= 1'b0;
         end
      end
      assign vld[g]      = vld_q;
      assign lk_match[g] = vld_q && (addr_q == lk_addr);
   end

   assign lk_hit = |lk_match;
endmodule

// File: rtl/pbsel_top.sv
module pbsel_top
   import pbsel_pkg::*;
#(
   parameter int ENTRIES      = 32,
   parameter int ADDR_W       = 40,
   parameter int DATA_W       = 64,
   parameter bit EARLY_INSERT = 1'b1,
   localparam int SLOT_W      = slot_bits(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_write,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   output logic              bc_valid,
   input  logic              bc_ready,
   output logic              bc_write,
   output logic [ADDR_W-1:0] bc_addr,
   output logic [DATA_W-1:0] bc_data,
   output logic [SLOT_W-1:0] bc_slot,
   output logic              np_valid,
   input  logic              np_ready,
   output logic              np_write,
   output logic [ADDR_W-1:0] np_addr,
   output logic [DATA_W-1:0] np_data,
   output logic [SLOT_W-1:0] np_slot,
   input  logic              ev_valid,
   input  logic              ev_insert,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic              rsp_valid,
   input  logic [SLOT_W-1:0] rsp_slot
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("pbsel_top: ENTRIES must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("pbsel_top: ADDR_W and DATA_W must be positive");
   end

   logic              mir_hit, rq_hit, full, fire;
   logic [SLOT_W-1:0] slot;
   path_e             sel;

   pbsel_mirror #(
      .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IW(SLOT_W), .EARLY_INSERT(EARLY_INSERT)
   ) u_mirror (
      .clk(clk), .rst_n(rst_n),
      .ev_valid(ev_valid), .ev_insert(ev_insert), .ev_addr(ev_addr),
      .lk_addr(in_addr), .lk_hit(mir_hit));

   pbsel_reqtab #(
      .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IW(SLOT_W)
   ) u_reqtab (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(fire), .alloc_addr(in_addr), .alloc_idx(slot), .full(full),
      .rel_en(rsp_valid), .rel_slot(rsp_slot),
      .lk_addr(in_addr), .lk_hit(rq_hit));

   assign sel      = (mir_hit || rq_hit) ? PATH_BUF : PATH_NORM;
   assign bc_valid = in_valid && !full && (sel == PATH_BUF);
   assign np_valid = in_valid && !full && (sel == PATH_NORM);
   assign in_ready = !full && ((sel == PATH_BUF) ? bc_ready : np_ready);
   assign fire     = in_valid && in_ready;

   assign bc_write = in_write;
   assign bc_addr  = in_addr;
   assign bc_data  = in_data;
   assign bc_slot  = slot;
   assign np_write = in_write;
   assign np_addr  = in_addr;
   assign np_data  = in_data;
   assign np_slot  = slot;
endmodule

// File: rtl/pbsel_chk.sv
module pbsel_chk #(
   parameter int ENTRIES = 32,
   parameter int ADDR_W  = 40,
   parameter int SLOT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              in_write,
   input logic [ADDR_W-1:0] in_addr,
   input logic              bc_valid,
   input logic              bc_ready,
   input logic [SLOT_W-1:0] bc_slot,
   input logic              np_valid,
   input logic              np_ready,
   input logic [SLOT_W-1:0] np_slot,
   input logic              ev_valid,
   input logic              ev_insert,
   input logic [ADDR_W-1:0] ev_addr,
   input logic              rsp_valid,
   input logic [SLOT_W-1:0] rsp_slot
);
   logic [ENTRIES-1:0] busy, same_addr;
   logic               fire;
   logic [SLOT_W-1:0]  got_slot;

   assign fire     = in_valid && in_ready;
   assign got_slot = bc_valid ? bc_slot : np_slot;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_trk
      logic              b_q;
      logic [ADDR_W-1:0] a_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            b_q <= 1'b0;
            a_q <= '0;
         end else if (fire && got_slot == SLOT_W'(g)) begin
            b_q <= 1'b1;
            a_q <= in_addr;
         end else if (rsp_valid && rsp_slot == SLOT_W'(g)) begin
            b_q <= 1'b0;
         end
      end
      assign busy[g]      = b_q;
      assign same_addr[g] = b_q && (a_q == in_addr);
   end

   a_r4_one_path: assert property (@(posedge clk) disable iff (!rst_n)
      !(bc_valid && np_valid));
   a_r6_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (&busy) |-> (!in_ready && !bc_valid && !np_valid));
   a_r3_fresh_slot: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !busy[got_slot]);
   a_r5_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_write && (|same_addr)) |-> !np_valid);
   a_r7_bc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && !bc_ready) |-> !in_ready);
   a_r7_np_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (np_valid && !np_ready) |-> !in_ready);
   a_r2_early_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_insert && in_valid && ev_addr == in_addr) |-> !np_valid);
endmodule

bind pbsel_top pbsel_chk #(
   .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_write(in_write), .in_addr(in_addr),
   .bc_valid(bc_valid), .bc_ready(bc_ready), .bc_slot(bc_slot),
   .np_valid(np_valid), .np_ready(np_ready), .np_slot(np_slot),
   .ev_valid(ev_valid), .ev_insert(ev_insert), .ev_addr(ev_addr),
   .rsp_valid(rsp_valid), .rsp_slot(rsp_slot));

// File: tb/sim_pbsel_top.sv
`timescale 1ns/1ps
module sim_pbsel_top;
   localparam int EN = 4, AW = 4, DW = 8, SW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          in_valid = 0, in_ready, in_write = 0;
   logic [AW-1:0] in_addr = '0;
   logic [DW-1:0] in_data = '0;
   logic          bc_valid, bc_ready = 1, bc_write;
   logic [AW-1:0] bc_addr;
   logic [DW-1:0] bc_data;
   logic [SW-1:0] bc_slot;
   logic          np_valid, np_ready = 1, np_write;
   logic [AW-1:0] np_addr;
   logic [DW-1:0] np_data;
   logic [SW-1:0] np_slot;
   logic          ev_valid = 0, ev_insert = 0;
   logic [AW-1:0] ev_addr = '0;
   logic          rsp_valid = 0;
   logic [SW-1:0] rsp_slot = '0;

   pbsel_top #(.ENTRIES(EN), .ADDR_W(AW), .DATA_W(DW)) u0 (.*);

   int n_vec = 0, n_bad = 0;
   bit mir [16];
   bit rq_v [EN];
   int rq_a [EN];

   task automatic chk(string tag, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int low_free();
      for (int i = 0; i < EN; i++) if (!rq_v[i]) return i;
      return -1;
   endfunction

   // one cycle: all side inputs are set by the caller before the call
   task automatic cyc(bit req, bit wr, int a, string tag);
      bit hit, full, eb, en, er;
      int fs, d;
      d = (a * 13 + wr * 5 + n_vec) % 256;
      in_valid = req; in_write = wr; in_addr = AW'(a); in_data = DW'(d);
      #1;
      hit = mir[a] || (ev_valid && ev_insert && int'(ev_addr) == a);
      for (int i = 0; i < EN; i++) if (rq_v[i] && rq_a[i] == a) hit = 1;
      fs = low_free();
      full = (fs < 0);
      eb = req && !full && hit;
      en = req && !full && !hit;
      er = !full && (hit ? bc_ready : np_ready);
      chk({tag, " bc_valid"}, int'(bc_valid), int'(eb));
      chk({tag, " np_valid"}, int'(np_valid), int'(en));
      if (req) chk({tag, " in_ready"}, int'(in_ready), int'(er));
      if (eb && er) chk("R3 bc_slot", int'(bc_slot), fs);
      if (en && er) chk("R3 np_slot", int'(np_slot), fs);
      if (eb) begin
         chk("R8 bc_addr", int'(bc_addr), a);
         chk("R8 bc_data", int'(bc_data), d);
         chk("R8 bc_write", int'(bc_write), int'(wr));
      end
      if (en) begin
         chk("R8 np_addr", int'(np_addr), a);
         chk("R8 np_data", int'(np_data), d);
         chk("R8 np_write", int'(np_write), int'(wr));
      end
      @(posedge clk);
      if (rsp_valid) rq_v[rsp_slot] = 0;
      if (req && er) begin rq_v[fs] = 1; rq_a[fs] = a; end
      if (ev_valid) mir[ev_addr] = ev_insert;
      #1;
      in_valid = 0; ev_valid = 0; rsp_valid = 0; bc_ready = 1; np_ready = 1;
   endtask

   task automatic release_slot(int s);
      rsp_valid = 1; rsp_slot = SW'(s);
      cyc(0, 0, 0, "R3");
   endtask

   task automatic status_ev(bit ins, int a);
      ev_valid = 1; ev_insert = ins; ev_addr = AW'(a);
      cyc(0, 0, 0, "R2");
   endtask

   task automatic sweep(string tag);
      for (int a = 0; a < 16; a++)
         for (int w = 0; w < 2; w++) begin
            cyc(1, w[0], a, tag);
            release_slot(0);
         end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: empty after reset
      cyc(0, 0, 0, "R1");
      sweep("R1");
      // R4: shadow entries steer reads and writes
      status_ev(1, 3);
      status_ev(1, 9);
      sweep("R4");
      // R3: lowest free slot; R5: write behind an in-flight read
      cyc(1, 0, 1, "R3");
      cyc(1, 0, 2, "R3");
      release_slot(0);
      cyc(1, 0, 4, "R3");
      cyc(1, 1, 2, "R5");
      release_slot(1);
      release_slot(0);
      release_slot(2);
      cyc(1, 1, 2, "R5");
      release_slot(0);
      // R6: table full
      cyc(1, 0, 1, "R6");
      cyc(1, 0, 2, "R6");
      cyc(1, 0, 4, "R6");
      cyc(1, 0, 5, "R6");
      cyc(1, 0, 10, "R6");
      cyc(1, 1, 3, "R6");
      rsp_valid = 1; rsp_slot = 2'd2;
      cyc(1, 0, 10, "R3");
      cyc(1, 0, 10, "R3");
      for (int s = 0; s < EN; s++) release_slot(s);
      // R7: per-path ready
      bc_ready = 0;
      cyc(1, 1, 3, "R7");
      cyc(1, 1, 3, "R7");
      release_slot(0);
      np_ready = 0;
      cyc(1, 0, 6, "R7");
      np_ready = 0;
      cyc(1, 0, 9, "R7");
      release_slot(0);
      // R2: same-cycle release still hits
      ev_valid = 1; ev_insert = 0; ev_addr = 4'd3;
      cyc(1, 0, 3, "R2");
      release_slot(0);
      cyc(1, 0, 3, "R2");
      release_slot(0);
      // R2: same-cycle insert hits
      ev_valid = 1; ev_insert = 1; ev_addr = 4'd12;
      cyc(1, 1, 12, "R2");
      release_slot(0);
      status_ev(0, 12);
      status_ev(0, 9);
      // R2: duplicate insert uses one entry
      status_ev(1, 7);
      status_ev(1, 7);
      status_ev(1, 1);
      status_ev(1, 2);
      status_ev(1, 4);
      sweep("R2");
      status_ev(0, 7);
      cyc(1, 0, 7, "R2");
      release_slot(0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5.0);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule